// File: doc/BRIEF.md
# Sixteen-Operation Data-Processing ALU

This block is the combinational arithmetic and logic stage of a small load/store processor core. Each cycle it receives a 4-bit operation code, a first operand taken from the register file and a second operand that an upstream shifter or immediate expander has already prepared. It returns the 32-bit outcome, an indication of whether the destination register should be written, and the new negative, zero, carry and overflow flags.

Arithmetic operations share a single adder. The adder's operand order is swapped for the reverse forms, and the second input is inverted for subtraction, so that a carry-out of 1 means that no borrow occurred. Logical and move operations take their carry from the shifter and keep the previous overflow flag. Four compare and test operations produce flags only and never request a register write. The condition check, the shifter and the decision about flag updates all live outside. The flag-update enable is the only control input from that logic that this block uses.

Top module: `dp_alu`

## Requirements
- R1: The operation code selects the operation: 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN.
- R2: MOV (13) outputs operand_b unchanged and MVN (15) outputs its bitwise complement. In both, the value of operand_a has no effect on result or flags_out.
- R3: ADD gives a+b and ADC gives a+b+C, where C is flags_in[1]. CMN (11) evaluates a+b.
- R4: SUB gives a-b and SBC gives a-b-(NOT C). CMP (10) evaluates a-b.
- R5: RSB gives b-a and RSC gives b-a-(NOT C).
- R6: AND, EOR and ORR give a&b, a^b and a|b. BIC gives a&~b. TST (8) evaluates a&b and TEQ (9) evaluates a^b.
- R7: dest_we is 0 for the four compare/test codes (8 to 11) and 1 for every other code.
- R8: Flags are packed as flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V. For an arithmetic operation that updates flags, C is the adder carry-out (1 means no borrow for the subtracting forms) and V is signed two's-complement overflow.
- R9: For a logical or move operation that updates flags, C equals shifter_carry and V equals flags_in[0].
- R10: When flags are updated, N equals result bit 31 and Z is 1 exactly when result is all zeros.
- R11: When set_flags is 0 and the code is not 8 to 11, flags_out equals flags_in. Codes 8 to 11 update flags whatever set_flags is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select (encoding in R1) |
| operand_a | input | 32 | First operand |
| operand_b | input | 32 | Second operand, already shifted or expanded |
| flags_in | input | 4 | Current N, Z, C, V flags |
| shifter_carry | input | 1 | Carry produced by the upstream shifter |
| set_flags | input | 1 | Flag-update enable for non-compare operations |
| result | output | 32 | Operation outcome |
| dest_we | output | 1 | Destination register write request |
| flags_out | output | 4 | Next N, Z, C, V flags |

## Verification
Every output is a combinational function of the present inputs, so result, dest_we and flags_out are valid in the same cycle the stimulus is applied, with no register delay. The bench changes inputs just after a rising clock edge and samples all three outputs at the following falling edge, half a period later. Each vector is therefore checked against the input set that produced it, and all inputs have settled by the time of sampling.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLG_N  = 3;
  localparam int unsigned FLG_Z  = 2;
  localparam int unsigned FLG_C  = 1;
  localparam int unsigned FLG_V  = 0;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef enum logic [2:0] {
    LOG_AND  = 3'd0,
    LOG_XOR  = 3'd1,
    LOG_OR   = 3'd2,
    LOG_BIC  = 3'd3,
    LOG_PASS = 3'd4,
    LOG_NOT  = 3'd5
  } log_sel_e;

  typedef struct packed {
    logic     is_arith;
    logic     is_test;
    logic     swap;
    logic     inv_y;
    cin_sel_e cin_sel;
    log_sel_e log_sel;
  } alu_ctrl_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_code,
  output alu_ctrl_t  ctrl
);

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  always_comb begin
    ctrl          = '0;
    ctrl.cin_sel  = CIN_ZERO;
    ctrl.log_sel  = LOG_AND;
    unique case (op)
      OP_AND: ctrl.log_sel = LOG_AND;
      OP_EOR: ctrl.log_sel = LOG_XOR;
      OP_ORR: ctrl.log_sel = LOG_OR;
      OP_BIC: ctrl.log_sel = LOG_BIC;
      OP_MOV: ctrl.log_sel = LOG_PASS;
      OP_MVN: ctrl.log_sel = LOG_NOT;
      OP_TST: begin
        ctrl.log_sel = LOG_AND;
        ctrl.is_test = 1'b1;
      end
      OP_TEQ: begin
        ctrl.log_sel = LOG_XOR;
        ctrl.is_test = 1'b1;
      end
      OP_ADD: begin
        ctrl.is_arith = 1'b1;
        ctrl.cin_sel  = CIN_ZERO;
      end
      OP_CMN: begin
        ctrl.is_arith = 1'b1;
        ctrl.is_test  = 1'b1;
        ctrl.cin_sel  = CIN_ZERO;
      end
      OP_ADC: begin
        ctrl.is_arith = 1'b1;
        ctrl.cin_sel  = CIN_FLAG;
      end
      OP_SUB: begin
        ctrl.is_arith = 1'b1;
        ctrl.inv_y    = 1'b1;
        ctrl.cin_sel  = CIN_ONE;
      end
      OP_CMP: begin
        ctrl.is_arith = 1'b1;
        ctrl.is_test  = 1'b1;
        ctrl.inv_y    = 1'b1;
        ctrl.cin_sel  = CIN_ONE;
      end
      OP_SBC: begin
        ctrl.is_arith = 1'b1;
        ctrl.inv_y    = 1'b1;
        ctrl.cin_sel  = CIN_FLAG;
      end
      OP_RSB: begin
        ctrl.is_arith = 1'b1;
        ctrl.swap     = 1'b1;
        ctrl.inv_y    = 1'b1;
        ctrl.cin_sel  = CIN_ONE;
      end
      OP_RSC: begin
        ctrl.is_arith = 1'b1;
        ctrl.swap     = 1'b1;
        ctrl.inv_y    = 1'b1;
        ctrl.cin_sel  = CIN_FLAG;
      end
      default: ctrl.log_sel = LOG_AND;
    endcase
  end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDER_STYLE = 0
) (
  input  logic [DATA_W-1:0] add_x,
  input  logic [DATA_W-1:0] add_y,
  input  logic              add_cin,
  output logic [DATA_W-1:0] add_sum,
  output logic              add_cout,
  output logic              add_ovf
);

  localparam int unsigned MSB = DATA_W - 1;

  // Sum and carry-out packed as {cout, sum}
  function automatic logic [DATA_W:0] add_wide(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y,
    input logic              c
  );
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, c};
  endfunction

  // Signed overflow: equal input signs, different result sign
  function automatic logic signed_ovf(
    input logic xs,
    input logic ys,
    input logic ss
  );
    return (xs == ys) && (ss != xs);
  endfunction

  generate
    if (ADDER_STYLE == 0) begin : g_behav
      logic [DATA_W:0] wide;
      assign wide     = add_wide(add_x, add_y, add_cin);
      assign add_sum  = wide[DATA_W-1:0];
      assign add_cout = wide[DATA_W];
      assign add_ovf  = signed_ovf(add_x[MSB], add_y[MSB], wide[MSB]);
    end else begin : g_ripple
      logic [DATA_W:0] chain;
      assign chain[0] = add_cin;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign add_sum[i]  = add_x[i] ^ add_y[i] ^ chain[i];
        assign chain[i+1]  = (add_x[i] & add_y[i]) | (chain[i] & (add_x[i] ^ add_y[i]));
      end
      assign add_cout = chain[DATA_W];
      assign add_ovf  = chain[DATA_W] ^ chain[DATA_W-1];
    end
  endgenerate

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] log_a,
  input  logic [DATA_W-1:0] log_b,
  input  log_sel_e          log_sel,
  output logic [DATA_W-1:0] log_out
);

  function automatic logic [DATA_W-1:0] bit_op(
    input log_sel_e            sel,
    input logic [DATA_W-1:0]   a,
    input logic [DATA_W-1:0]   b
  );
    case (sel)
      LOG_AND:  return a & b;
      LOG_XOR:  return a ^ b;
      LOG_OR:   return a | b;
      LOG_BIC:  return a & ~b;
      LOG_PASS: return b;
      LOG_NOT:  return ~b;
      default:  return a & b;
    endcase
  endfunction

  assign log_out = bit_op(log_sel, log_a, log_b);

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] fl_result,
  input  logic              fl_update,
  input  logic              fl_arith,
  input  logic              fl_cout,
  input  logic              fl_ovf,
  input  logic              fl_shift_c,
  input  logic [FLAG_W-1:0] fl_prev,
  output logic [FLAG_W-1:0] fl_next
);

  function automatic logic all_zero(input logic [DATA_W-1:0] v);
    return ~|v;
  endfunction

  logic [FLAG_W-1:0] computed;

  always_comb begin
    computed        = '0;
    computed[FLG_N] = fl_result[DATA_W-1];
    computed[FLG_Z] = all_zero(fl_result);
    computed[FLG_C] = fl_arith ? fl_cout : fl_shift_c;
    computed[FLG_V] = fl_arith ? fl_ovf  : fl_prev[FLG_V];
  end

  assign fl_next = fl_update ? computed : fl_prev;

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDER_STYLE = 0
) (
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] operand_a,
  input  logic [DATA_W-1:0] operand_b,
  input  logic [3:0]        flags_in,
  input  logic              shifter_carry,
  input  logic              set_flags,
  output logic [DATA_W-1:0] result,
  output logic              dest_we,
  output logic [3:0]        flags_out
);

  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] add_x;
  logic [DATA_W-1:0] y_raw;
  logic [DATA_W-1:0] add_y;
  logic              add_cin;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic              ovf;
  logic [DATA_W-1:0] log_out;

  // Named events exposed for the checker
  logic              arith_op;
  logic              test_op;
  logic              upd_flags;

  dp_alu_decode u_decode (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  assign arith_op  = ctrl.is_arith;
  assign test_op   = ctrl.is_test;
  assign upd_flags = set_flags | ctrl.is_test;

  // Operand steering for the shared adder
  assign add_x = ctrl.swap ? operand_b : operand_a;
  assign y_raw = ctrl.swap ? operand_a : operand_b;
  assign add_y = ctrl.inv_y ? ~y_raw : y_raw;

  always_comb begin
    case (ctrl.cin_sel)
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = flags_in[FLG_C];
      default:  add_cin = 1'b0;
    endcase
  end

  dp_alu_adder #(
    .DATA_W      (DATA_W),
    .ADDER_STYLE (ADDER_STYLE)
  ) u_adder (
    .add_x    (add_x),
    .add_y    (add_y),
    .add_cin  (add_cin),
    .add_sum  (sum),
    .add_cout (cout),
    .add_ovf  (ovf)
  );

  dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .log_a   (operand_a),
    .log_b   (operand_b),
    .log_sel (ctrl.log_sel),
    .log_out (log_out)
  );

  assign result  = arith_op ? sum : log_out;
  assign dest_we = ~test_op;

  dp_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .fl_result  (result),
    .fl_update  (upd_flags),
    .fl_arith   (arith_op),
    .fl_cout    (cout),
    .fl_ovf     (ovf),
    .fl_shift_c (shifter_carry),
    .fl_prev    (flags_in),
    .fl_next    (flags_out)
  );

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] operand_b,
  input logic [3:0]        flags_in,
  input logic              shifter_carry,
  input logic              set_flags,
  input logic [DATA_W-1:0] result,
  input logic              dest_we,
  input logic [3:0]        flags_out,
  input logic              arith_op,
  input logic              test_op,
  input logic              upd_flags
);

  always_comb begin
    // R7: compare/test codes never request a write
    p_no_write_on_test_r7: assert ((op_code[3:2] != 2'b10) || !dest_we)
      else $error("R7 write requested on compare/test");
    // R11: flags held when not updating
    p_flags_hold_r11: assert (set_flags || (op_code[3:2] == 2'b10) || (flags_out == flags_in))
      else $error("R11 flags changed without enable");
    // R10: N and Z follow the result when updating
    p_nz_track_r10: assert (!upd_flags ||
                            ((flags_out[3] == result[DATA_W-1]) && (flags_out[2] == (result == '0))))
      else $error("R10 N/Z mismatch");
    // R9: logical/move carry from shifter, V kept
    p_logic_cv_r9: assert (!upd_flags || arith_op ||
                           ((flags_out[1] == shifter_carry) && (flags_out[0] == flags_in[0])))
      else $error("R9 logical C/V mismatch");
    // R2: move passes operand_b, move-inverted complements it
    p_move_pass_r2: assert ((op_code != 4'd13) || (result == operand_b))
      else $error("R2 MOV result mismatch");
    p_move_not_r2: assert ((op_code != 4'd15) || (result == ~operand_b))
      else $error("R2 MVN result mismatch");
    // R7: test class and write enable are exclusive
    p_we_vs_test_r7: assert (test_op != dest_we)
      else $error("R7 write enable vs test class");
  end

endmodule

bind dp_alu dp_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .op_code       (op_code),
  .operand_b     (operand_b),
  .flags_in      (flags_in),
  .shifter_carry (shifter_carry),
  .set_flags     (set_flags),
  .result        (result),
  .dest_we       (dest_we),
  .flags_out     (flags_out),
  .arith_op      (arith_op),
  .test_op       (test_op),
  .upd_flags     (upd_flags)
);

// File: tb/dp_alu_tb_top.sv
`timescale 1ns/1ps
module dp_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] operand_a = '0;
  logic [31:0] operand_b = '0;
  logic [3:0]  flags_in = '0;
  logic        shifter_carry = 1'b0;
  logic        set_flags = 1'b0;
  logic [31:0] result;
  logic        dest_we;
  logic [3:0]  flags_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dp_alu dut_i (
    .op_code       (op_code),
    .operand_a     (operand_a),
    .operand_b     (operand_b),
    .flags_in      (flags_in),
    .shifter_carry (shifter_carry),
    .set_flags     (set_flags),
    .result        (result),
    .dest_we       (dest_we),
    .flags_out     (flags_out)
  );

  // Reference: 64-bit integer arithmetic, returns {we, flags, result}
  function automatic logic [36:0] model(
    input logic [3:0]  op,
    input logic [31:0] a,
    input logic [31:0] b,
    input logic [3:0]  fl,
    input logic        sc,
    input logic        sf
  );
    logic [31:0] r;
    logic        c, v, arith, tst;
    logic [3:0]  nf;
    longint      ua, ub, sa, sb, full, sfull, k;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    arith = 1'b1;
    c = 1'b0;
    v = 1'b0;
    r = '0;
    tst = (op >= 4'd8) && (op <= 4'd11);
    case (op)
      4'd4, 4'd11, 4'd5: begin
        k = (op == 4'd5) ? longint'(fl[1]) : 0;
        full = ua + ub + k;  sfull = sa + sb + k;
        r = full[31:0];  c = full > 64'sd4294967295;
        v = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
      end
      4'd2, 4'd10, 4'd6: begin
        k = (op == 4'd6) ? longint'(!fl[1]) : 0;
        full = ua - ub - k;  sfull = sa - sb - k;
        r = full[31:0];  c = ua >= ub + k;
        v = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
      end
      4'd3, 4'd7: begin
        k = (op == 4'd7) ? longint'(!fl[1]) : 0;
        full = ub - ua - k;  sfull = sb - sa - k;
        r = full[31:0];  c = ub >= ua + k;
        v = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
      end
      default: begin
        arith = 1'b0;
        case (op)
          4'd0, 4'd8:  r = a & b;
          4'd1, 4'd9:  r = a ^ b;
          4'd12:       r = a | b;
          4'd13:       r = b;
          4'd14:       r = a & ~b;
          default:     r = ~b;
        endcase
      end
    endcase
    if (sf || tst)
      nf = {r[31], (r == 32'd0), (arith ? c : sc), (arith ? v : fl[0])};
    else
      nf = fl;
    return {!tst, nf, r};
  endfunction

  task automatic apply_check(
    input string       tag,
    input logic [3:0]  op,
    input logic [31:0] a,
    input logic [31:0] b,
    input logic [3:0]  fl,
    input logic        sc,
    input logic        sf
  );
    logic [36:0] exp;
    @(posedge clk);
    #1;
    op_code = op; operand_a = a; operand_b = b;
    flags_in = fl; shifter_carry = sc; set_flags = sf;
    exp = model(op, a, b, fl, sc, sf);
    @(negedge clk);
    checks++;
    if ({dest_we, flags_out, result} !== exp) begin
      failures++;
      $display("FAIL %s op=%0d: got we=%b fl=%b res=%h, expected we=%b fl=%b res=%h",
               tag, op, dest_we, flags_out, result, exp[36], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    checks++;
    if (result !== 32'd0 || dest_we !== 1'b1 || flags_out !== 4'd0) begin
      failures++;
      $display("FAIL R1 idle: got res=%h we=%b fl=%b, expected 0/1/0", result, dest_we, flags_out);
    end
  endtask

  task automatic t_move();
    apply_check("R2 mov", 4'd13, 32'hDEAD_BEEF, 32'h1234_5678, 4'b0000, 1'b1, 1'b1);
    apply_check("R2 mov a-ignored", 4'd13, 32'h0000_0000, 32'h1234_5678, 4'b0000, 1'b1, 1'b1);
    apply_check("R2 mvn", 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0001, 1'b0, 1'b1);
    apply_check("R2 mvn a-ignored", 4'd15, 32'h5555_0000, 32'hFFFF_FFFF, 4'b0001, 1'b0, 1'b1);
  endtask

  task automatic t_add();
    apply_check("R3 add", 4'd4, 32'd100, 32'd23, 4'b0000, 1'b0, 1'b1);
    apply_check("R3 add carry-out", 4'd4, 32'hFFFF_FFFF, 32'd1, 4'b0000, 1'b0, 1'b1);
    apply_check("R3 adc cin", 4'd5, 32'd7, 32'd8, 4'b0010, 1'b0, 1'b1);
    apply_check("R3 adc no cin", 4'd5, 32'd7, 32'd8, 4'b0000, 1'b0, 1'b1);
    apply_check("R3 cmn", 4'd11, 32'hFFFF_FFFE, 32'd2, 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic t_sub();
    apply_check("R4 sub", 4'd2, 32'd50, 32'd8, 4'b0000, 1'b0, 1'b1);
    apply_check("R4 sub borrow", 4'd2, 32'd3, 32'd5, 4'b0000, 1'b0, 1'b1);
    apply_check("R4 sbc c=1", 4'd6, 32'd10, 32'd4, 4'b0010, 1'b0, 1'b1);
    apply_check("R4 sbc c=0", 4'd6, 32'd10, 32'd4, 4'b0000, 1'b0, 1'b1);
    apply_check("R4 cmp equal", 4'd10, 32'd77, 32'd77, 4'b1001, 1'b0, 1'b0);
  endtask

  task automatic t_rsub();
    apply_check("R5 rsb", 4'd3, 32'd8, 32'd50, 4'b0000, 1'b0, 1'b1);
    apply_check("R5 rsb neg", 4'd3, 32'd50, 32'd8, 4'b0000, 1'b0, 1'b1);
    apply_check("R5 rsc c=0", 4'd7, 32'd1, 32'd1, 4'b0000, 1'b0, 1'b1);
    apply_check("R5 rsc c=1", 4'd7, 32'd1, 32'd1, 4'b0010, 1'b0, 1'b1);
  endtask

  task automatic t_logic();
    apply_check("R6 and", 4'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0000, 1'b1, 1'b1);
    apply_check("R6 eor", 4'd1, 32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0000, 1'b0, 1'b1);
    apply_check("R6 orr", 4'd12, 32'h0000_00F0, 32'h0F00_0000, 4'b0000, 1'b0, 1'b1);
    apply_check("R6 bic", 4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0000, 1'b1, 1'b1);
    apply_check("R6 tst", 4'd8, 32'hAAAA_AAAA, 32'h5555_5555, 4'b0000, 1'b1, 1'b0);
    apply_check("R6 teq", 4'd9, 32'h8000_0001, 32'h0000_0001, 4'b0001, 1'b0, 1'b0);
  endtask

  task automatic t_write_enable();
    for (int op = 0; op < 16; op++)
      apply_check("R7 we", op[3:0], 32'h1357_9BDF, 32'h0246_8ACE, 4'b0110, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    apply_check("R8 add pos ovf", 4'd4, 32'h7FFF_FFFF, 32'd1, 4'b0000, 1'b0, 1'b1);
    apply_check("R8 add neg ovf", 4'd4, 32'h8000_0000, 32'h8000_0000, 4'b0000, 1'b0, 1'b1);
    apply_check("R8 sub ovf", 4'd2, 32'h8000_0000, 32'd1, 4'b0000, 1'b0, 1'b1);
    apply_check("R8 rsb ovf", 4'd3, 32'd1, 32'h8000_0000, 4'b0000, 1'b0, 1'b1);
    apply_check("R8 sub zero no borrow", 4'd2, 32'd0, 32'd0, 4'b0000, 1'b0, 1'b1);
  endtask

  task automatic t_logic_flags();
    apply_check("R9 shifter c=1 v kept", 4'd0, 32'h1, 32'h1, 4'b0001, 1'b1, 1'b1);
    apply_check("R9 shifter c=0 v kept", 4'd12, 32'h0, 32'h0, 4'b0011, 1'b0, 1'b1);
    apply_check("R10 negative", 4'd13, 32'h0, 32'h8000_0000, 4'b0000, 1'b0, 1'b1);
    apply_check("R10 zero", 4'd1, 32'hCAFE_F00D, 32'hCAFE_F00D, 4'b1000, 1'b0, 1'b1);
  endtask

  task automatic t_flag_hold();
    apply_check("R11 hold add", 4'd4, 32'hFFFF_FFFF, 32'd1, 4'b1010, 1'b0, 1'b0);
    apply_check("R11 hold mov", 4'd13, 32'h0, 32'h0, 4'b0101, 1'b1, 1'b0);
    apply_check("R11 test forces", 4'd10, 32'd1, 32'd2, 4'b0000, 1'b1, 1'b0);
  endtask

  initial begin
    #20;
    rst_n = 1'b1;
    t_reset_state();
    t_move();
    t_add();
    t_sub();
    t_rsub();
    t_logic();
    t_write_enable();
    t_overflow();
    t_logic_flags();
    t_flag_hold();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule